// File: doc/BRIEF.md
# SPI Serial Clock and Frame Timing Generator

This block times one serial frame for an SPI controller. On a start strobe it samples a 27-bit configuration word, a frame length and a hold request. It then drives chip select and the serial clock through four phases: a setup wait after chip select goes active, the clocked bits, a wait after the last clock edge, and an idle gap. The gap is skipped when chip select is to stay asserted into the next frame. For every clock transition it gives the data shifter a single-cycle strobe, and it ends each frame with a one-cycle done pulse.

Each interval is the product of a small prescaler and a scaler, so long delays need only a few configuration bits. The serial clock ratio is a prescaler of 2, 3, 5 or 7 times a scaler from a table that grows in steps at first and then in powers of two. A double-rate bit halves the ratio, which allows the system clock divided by two. Software chooses the field values. This block only turns them into cycles.

Top module: `sck_timing_gen`

## Requirements
- R1: While reset is held and after it is released, sck, cs_active, lead_edge, trail_edge and done are all 0.
- R2: The SCK period in system clocks is P x S, halved when cfg bit 24 is set. P is chosen by cfg[17:16] (0..3 gives 2, 3, 5, 7). S is chosen by cfg[3:0]: codes 0..3 give 2, 4, 6, 8 and a code c of 4 or more gives 2^c. With bit 24 set and both codes 0, the period is 2.
- R3: Within each bit, the first SCK half lasts floor(ratio/2) system clocks and the second half lasts the rest, so an odd ratio puts its extra clock in the second half.
- R4: Each delay is Q x 2^(n+1) system clocks, with Q = 1, 3, 5, 7 for prescaler codes 0..3. The chip-select-to-clock delay uses cfg[23:22] and cfg[15:12]. The after-clock delay uses cfg[21:20] and cfg[11:8]. The inter-frame gap uses cfg[19:18] and cfg[7:4].
- R5: If the start strobe is sampled at clock edge 0, cs_active is 1 from cycle 0. The clocked bits begin at cycle Dcs. done is high in cycle Dcs + N x ratio + Dafter + Dgap, where N = frame_bits_m1 + 1 and Dgap counts as 0 when chip select is held.
- R6: The idle SCK level equals cfg bit 26. When cfg bit 25 is 0, the first transition of a bit comes after the first half. When it is 1, the first transition comes at the start of the bit.
- R7: Each frame gives exactly N lead_edge and N trail_edge pulses. Each pulse is high in the cycle where sck first shows its new level: lead_edge for a move away from the idle level, trail_edge for a move back to it. The two pulses are never high together, and only while cs_active is 1.
- R8: If hold_cs is sampled high, chip select stays asserted through the done cycle and in idle until the next frame begins, and the gap is skipped. Otherwise cs_active is 0 during the gap and at done.
- R9: Configuration, frame length and hold are sampled only at a start taken while idle. A start strobe or an input change during a frame has no effect on that frame, and the idle SCK level keeps the value sampled at the last accepted start.
- R10: done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame start strobe, taken only while idle |
| cfg_word | input | 27 | Timing configuration (fields as in R2, R4, R6) |
| frame_bits_m1 | input | 5 | Frame length minus one |
| hold_cs | input | 1 | Keep chip select asserted after this frame |
| sck | output | 1 | Serial clock |
| cs_active | output | 1 | Chip-select enable, active high |
| lead_edge | output | 1 | Strobe for the clock moving away from idle |
| trail_edge | output | 1 | Strobe for the clock returning to idle |
| done | output | 1 | End-of-frame pulse |

## Verification
All cycle counts are taken from the first edge that samples start, counted as cycle 0. cs_active rises in cycle 0. The first lead_edge is due at Dcs plus floor(ratio/2) when phase is 0, or at Dcs when phase is 1. done is due at the R5 total. The bench drives inputs on falling edges and records each output once per cycle at the falling edge, so every event is logged with its own cycle index. Those indices are compared with positions worked out by hand from the field formulas: first lead, lead spacing, lead-to-trail spacing, edge counts, done cycle, and chip select in the cycles around done.

// File: rtl/stc_pkg.sv
// Shared constants and types for the SPI timing generator.
// Assumes a 27-bit configuration word whose field positions are fixed here.
package stc_pkg;
    localparam int CFG_W  = 27;
    localparam int CNT_W  = 19;          // holds 7 * 2^16, the longest interval
    localparam int N_DLY  = 3;           // cs-to-clock, after-clock, gap

    localparam int POL_BIT      = 26;
    localparam int PHA_BIT      = 25;
    localparam int FAST_BIT     = 24;
    localparam int BAUD_PRE_LSB = 16;
    localparam int BAUD_SCL_LSB = 0;

    localparam int DLY_PRE_LSB [N_DLY] = '{22, 20, 18};
    localparam int DLY_EXP_LSB [N_DLY] = '{12, 8, 4};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK,
        ST_TRAIL,
        ST_GAP,
        ST_DONE
    } stc_state_e;
endpackage

// File: rtl/stc_delay_calc.sv
// Converts an odd prescaler code and an exponent code into a delay in
// system clocks: (2*pre+1) * 2^(exp+1). Purely combinational.
module stc_delay_calc #(
    parameter int CNT_W = 19
) (
    input  logic [1:0]       pre_sel,
    input  logic [3:0]       exp_sel,
    output logic [CNT_W-1:0] cycles
);
    logic [4:0]       shift_amt;
    logic [CNT_W-1:0] odd_base;

    // odd prescaler 1/3/5/7 shifted by exp+1
    always_comb begin
        shift_amt = {1'b0, exp_sel} + 5'd1;
        odd_base  = CNT_W'({pre_sel, 1'b1});
        cycles    = odd_base << shift_amt;
    end
endmodule

// File: rtl/stc_baud_calc.sv
// Computes the serial clock ratio in system clocks from the baud prescaler
// code, the baud scaler code and the double-rate bit. Combinational.
module stc_baud_calc #(
    parameter int CNT_W = 19
) (
    input  logic [1:0]       pre_sel,
    input  logic [3:0]       scl_sel,
    input  logic             fast,
    output logic [CNT_W-1:0] ratio
);
    logic [CNT_W-1:0] pre_v;
    logic [CNT_W-1:0] scl_v;
    logic [CNT_W-1:0] prod;

    // prime prescaler, stepped-then-binary scaler, optional halving
    always_comb begin
        case (pre_sel)
            2'd0:    pre_v = CNT_W'(2);
            2'd1:    pre_v = CNT_W'(3);
            2'd2:    pre_v = CNT_W'(5);
            default: pre_v = CNT_W'(7);
        endcase
        if (scl_sel < 4'd4) scl_v = CNT_W'({scl_sel, 1'b0}) + CNT_W'(2);
        else                scl_v = CNT_W'(1) << scl_sel;
        prod  = pre_v * scl_v;
        ratio = fast ? (prod >> 1) : prod;
    end
endmodule

// File: rtl/stc_frame_seq.sv
// Frame sequencer: captures the decoded timing at an accepted start and
// walks setup delay, clocked bits, after-clock delay and gap. Assumes every
// interval is at least 1 and the ratio at least 2 (guaranteed by the tables).
module stc_frame_seq
    import stc_pkg::*;
#(
    parameter int BITS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  ratio_in,
    input  logic [CNT_W-1:0]  dcs_in,
    input  logic [CNT_W-1:0]  daf_in,
    input  logic [CNT_W-1:0]  dgap_in,
    input  logic              cpol_in,
    input  logic              cpha_in,
    input  logic [BITS_W-1:0] nbm1_in,
    input  logic              hold_in,
    output logic              accept,
    output logic              sck,
    output logic              cs_active,
    output logic              lead_edge,
    output logic              trail_edge,
    output logic              done
);
    stc_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q, r_q, dcs_q, daf_q, dgap_q;
    logic [CNT_W-1:0]  h1, h2, limit;
    logic [BITS_W-1:0] nbm1_q, bit_q;
    logic              half_q, cpol_q, cpha_q, hold_q;
    logic              cnt_last, in_clk, phase_start, first_lvl;

    assign accept = start && (state_q == ST_IDLE);

    // hold the frame's timing fixed from the accepted start onward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0; dcs_q <= '0; daf_q <= '0; dgap_q <= '0;
            nbm1_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; hold_q <= 1'b0;
        end else if (accept) begin
            r_q <= ratio_in; dcs_q <= dcs_in; daf_q <= daf_in; dgap_q <= dgap_in;
            nbm1_q <= nbm1_in; cpol_q <= cpol_in; cpha_q <= cpha_in; hold_q <= hold_in;
        end
    end

    // length of the current phase and its terminal count
    always_comb begin
        h1 = r_q >> 1;
        h2 = r_q - h1;
        case (state_q)
            ST_LEAD:  limit = dcs_q;
            ST_CLK:   limit = half_q ? h2 : h1;
            ST_TRAIL: limit = daf_q;
            ST_GAP:   limit = dgap_q;
            default:  limit = CNT_W'(1);
        endcase
        cnt_last = (cnt_q == limit - CNT_W'(1));
    end

    // phase and bit sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            half_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_LEAD;
                    cnt_q   <= '0;
                end
                ST_LEAD: if (cnt_last) begin
                    state_q <= ST_CLK;
                    cnt_q   <= '0;
                    bit_q   <= '0;
                    half_q  <= 1'b0;
                end else cnt_q <= cnt_q + CNT_W'(1);
                ST_CLK: if (cnt_last) begin
                    cnt_q <= '0;
                    if (half_q) begin
                        half_q <= 1'b0;
                        if (bit_q == nbm1_q) state_q <= ST_TRAIL;
                        else                 bit_q <= bit_q + BITS_W'(1);
                    end else half_q <= 1'b1;
                end else cnt_q <= cnt_q + CNT_W'(1);
                ST_TRAIL: if (cnt_last) begin
                    cnt_q   <= '0;
                    state_q <= hold_q ? ST_DONE : ST_GAP;
                end else cnt_q <= cnt_q + CNT_W'(1);
                ST_GAP: if (cnt_last) begin
                    cnt_q   <= '0;
                    state_q <= ST_DONE;
                end else cnt_q <= cnt_q + CNT_W'(1);
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // clock level, edge strobes and chip select from the registered state
    always_comb begin
        in_clk      = (state_q == ST_CLK);
        phase_start = in_clk && (cnt_q == '0);
        first_lvl   = cpol_q ^ cpha_q;
        sck         = in_clk ? (half_q ? ~first_lvl : first_lvl) : cpol_q;
        if (cpha_q) begin
            lead_edge  = phase_start && !half_q;
            trail_edge = phase_start && half_q;
        end else begin
            lead_edge  = phase_start && half_q;
            trail_edge = (phase_start && !half_q && (bit_q != '0)) ||
                         ((state_q == ST_TRAIL) && (cnt_q == '0));
        end
        cs_active = (state_q == ST_LEAD) || in_clk || (state_q == ST_TRAIL) ||
                    (hold_q && ((state_q == ST_DONE) || (state_q == ST_IDLE)));
        done      = (state_q == ST_DONE);
    end
endmodule

// File: rtl/sck_timing_gen.sv
// Top of the SPI clock and frame timing generator. Decodes the configuration
// word into a clock ratio and three delays, then hands them to the sequencer.
// Assumes start is a synchronous strobe; it is ignored while a frame runs.
module sck_timing_gen
    import stc_pkg::*;
#(
    parameter int BITS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [BITS_W-1:0] frame_bits_m1,
    input  logic              hold_cs,
    output logic              sck,
    output logic              cs_active,
    output logic              lead_edge,
    output logic              trail_edge,
    output logic              done
);
    logic [CNT_W-1:0] baud_ratio;
    logic [CNT_W-1:0] dly_cyc [N_DLY];
    logic             seq_accept;

    stc_baud_calc #(.CNT_W(CNT_W)) u_baud (
        .pre_sel (cfg_word[BAUD_PRE_LSB +: 2]),
        .scl_sel (cfg_word[BAUD_SCL_LSB +: 4]),
        .fast    (cfg_word[FAST_BIT]),
        .ratio   (baud_ratio)
    );

    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        stc_delay_calc #(.CNT_W(CNT_W)) u_dly (
            .pre_sel (cfg_word[DLY_PRE_LSB[g] +: 2]),
            .exp_sel (cfg_word[DLY_EXP_LSB[g] +: 4]),
            .cycles  (dly_cyc[g])
        );
    end

    stc_frame_seq #(.BITS_W(BITS_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ratio_in   (baud_ratio),
        .dcs_in     (dly_cyc[0]),
        .daf_in     (dly_cyc[1]),
        .dgap_in    (dly_cyc[2]),
        .cpol_in    (cfg_word[POL_BIT]),
        .cpha_in    (cfg_word[PHA_BIT]),
        .nbm1_in    (frame_bits_m1),
        .hold_in    (hold_cs),
        .accept     (seq_accept),
        .sck        (sck),
        .cs_active  (cs_active),
        .lead_edge  (lead_edge),
        .trail_edge (trail_edge),
        .done       (done)
    );
endmodule

// File: rtl/sck_timing_gen_chk.sv
// Protocol checker for the timing generator, attached by bind below.
// Assumes the same clock and synchronous active-low reset as the design.
module sck_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic accept,
    input logic sck,
    input logic cs_active,
    input logic lead_edge,
    input logic trail_edge,
    input logic done
);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_edge_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_edge && trail_edge));

    p_edge_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_edge || trail_edge) |-> cs_active);

    p_lead_moves_sck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_edge |-> (sck != $past(sck)));

    p_trail_moves_sck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_edge |-> (sck != $past(sck)));

    p_sck_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead_edge && !trail_edge && !$past(accept)) |-> $stable(sck));

    p_accept_raises_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cs_active);
endmodule

bind sck_timing_gen sck_timing_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (seq_accept),
    .sck        (sck),
    .cs_active  (cs_active),
    .lead_edge  (lead_edge),
    .trail_edge (trail_edge),
    .done       (done)
);

// File: tb/sck_timing_gen_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, hold, mid-frame starts and the retained idle level.
module sck_timing_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [26:0] cfg;
        logic [4:0]  nbm1;
        logic        hold;
        logic [31:0] t_done;   // cycle of done
        logic [31:0] t_lead;   // cycle of first lead_edge
        logic [31:0] period;   // lead to lead spacing
        logic [31:0] l2t;      // first lead to following trail
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{27'h0000000, 5'd7,  1'b0, 32'd38,  32'd4,  32'd4,   32'd2},
        '{27'h066D1001, 5'd3, 1'b0, 32'd84,  32'd12, 32'd12,  32'd6},
        '{27'h0101_0000, 5'd4, 1'b1, 32'd19, 32'd3,  32'd3,   32'd2},
        '{27'h0206_0322, 5'd0, 1'b0, 32'd72, 32'd2,  32'd30,  32'd15},
        '{27'h0500_0000, 5'd31, 1'b0, 32'd70, 32'd3, 32'd2,   32'd1},
        '{27'h0003_0004, 5'd1, 1'b0, 32'd230, 32'd58, 32'd112, 32'd56}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [26:0] cfg_word = '0;
    logic [4:0]  frame_bits_m1 = '0;
    logic        hold_cs = 1'b0;
    logic        sck, cs_active, lead_edge, trail_edge, done;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sck_timing_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cfg_word      (cfg_word),
        .frame_bits_m1 (frame_bits_m1),
        .hold_cs       (hold_cs),
        .sck           (sck),
        .cs_active     (cs_active),
        .lead_edge     (lead_edge),
        .trail_edge    (trail_edge),
        .done          (done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one frame; poke >= 0 pulses start with other settings mid-frame (R9)
    task automatic run_frame(input vec_t v, input int poke);
        int n, first_lead, second_lead, trail_after, leads, trails;
        int done_at, done_cnt, cs0, sck0, cs_prev, cs_done;
        n = int'(v.nbm1) + 1;
        first_lead = -1; second_lead = -1; trail_after = -1;
        leads = 0; trails = 0; done_at = -1; done_cnt = 0;
        cs0 = 0; sck0 = 0; cs_prev = -1; cs_done = -1;
        @(negedge clk);
        cfg_word = v.cfg; frame_bits_m1 = v.nbm1; hold_cs = v.hold; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= int'(v.t_done) + 2; k++) begin
            if (k == 0) begin cs0 = int'(cs_active); sck0 = int'(sck); end
            if (lead_edge) begin
                leads++;
                if (first_lead < 0) first_lead = k;
                else if (second_lead < 0) second_lead = k;
            end
            if (trail_edge) begin
                trails++;
                if (first_lead >= 0 && trail_after < 0) trail_after = k;
            end
            if (done) begin done_cnt++; done_at = k; cs_done = int'(cs_active); end
            if (k == int'(v.t_done) - 1) cs_prev = int'(cs_active);
            if (k == poke) begin
                start = 1'b1; cfg_word = 27'h0003_0004; frame_bits_m1 = 5'd20; hold_cs = ~v.hold;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R5", "cs_active in cycle 0", cs0, 1);
        chk("R6", "sck idle level in setup", sck0, int'(v.cfg[26]));
        chk("R4", "first lead_edge cycle", first_lead, int'(v.t_lead));
        if (n > 1) chk("R2", "lead spacing", second_lead - first_lead, int'(v.period));
        chk("R3", "lead to trail spacing", trail_after - first_lead, int'(v.l2t));
        chk("R7", "lead_edge count", leads, n);
        chk("R7", "trail_edge count", trails, n);
        chk("R5", "done cycle", done_at, int'(v.t_done));
        chk("R10", "done pulses", done_cnt, 1);
        chk("R8", "cs before done", cs_prev, int'(v.hold));
        chk("R8", "cs at done", cs_done, int'(v.hold));
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: reset state, sampled during and after reset
        repeat (3) @(negedge clk);
        chk("R1", "sck in reset", int'(sck), 0);
        chk("R1", "cs in reset", int'(cs_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "edges after reset", int'(lead_edge | trail_edge), 0);
        chk("R1", "cs after reset", int'(cs_active), 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) run_frame(VECS[i], -1);

        // R9: start and new settings mid-frame leave the frame untouched
        run_frame(VECS[0], 5);

        // R8: held chip select stays active in idle, then released
        run_frame(VECS[2], -1);
        repeat (4) @(negedge clk);
        chk("R8", "cs held in idle", int'(cs_active), 1);
        run_frame(VECS[0], -1);
        chk("R8", "cs released after unheld frame", int'(cs_active), 0);

        // R9: idle level keeps the sampled polarity while the input changes
        run_frame(VECS[4], -1);
        cfg_word = '0;
        repeat (3) @(negedge clk);
        chk("R9", "idle sck keeps sampled polarity", int'(sck), 1);
        chk("R6", "no edges while idle", int'(lead_edge | trail_edge), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule